// File: doc/BRIEF.md
# Sectioned-Carry Phase Accumulator with Phase Offset

This block is the core of a numerically controlled oscillator. It has a 32-bit phase accumulator built as four 8-bit adder sections. Between each section and the next there is a carry register, so no adder path is longer than eight bits. Each section adds one byte of the frequency word to its own registered sum, plus the carry that the section below produced one clock earlier. Because of this, each section runs one clock behind the section beneath it. The caller therefore presents the frequency word skewed: byte k of a given word arrives k clocks after byte 0 of that word.

The most significant section's sum register is the 8-bit phase. A phase offset word is added to that phase, modulo 256, and the result is registered as the offset phase. The offset in radians is 2π/256 times the offset word. From each of the two phase values the block decodes a one-bit square sine and a one-bit square cosine. With the offset word at zero, the offset outputs are the plain outputs one clock later. With any other offset word, they are the plain outputs shifted by that offset. There are no states in this block: every register updates every clock.

Top module: `nco_pipe_core`

## Requirements
- R1: While `rst_n` is low, every sum and carry register is cleared and the offset phase register is cleared. As a result `phase_o` and `mod_phase_o` read 0, and `sin_o`, `cos_o`, `msin_o` and `mcos_o` read 1.
- R2: Number the rising edges after reset release as e = 1, 2, … and let W_e be the word whose byte 0 is on `freq_i[7:0]` at edge e. Byte k of W_e must be on `freq_i[8k+7:8k]` at edge e+k. Define A_e = A_(e-1) + W_e mod 2^32, with A_0 = 0. Then after edge e, `phase_o` equals bits 31:24 of A_(e-3).
- R3: A carry out of one 8-bit section enters the next section one clock later, so that repeated all-ones words give the same result as the full 32-bit sum.
- R4: When the word changes every clock, each byte lane of `freq_i` affects only its own section, and R2 still holds.
- R5: After edge e, `mod_phase_o` equals the `phase_o` value from before that edge plus the `pw_i` value sampled at that edge, modulo 256.
- R6: `sin_o` is 1 exactly when bit 7 of `phase_o` is 0.
- R7: `cos_o` is 1 exactly when bits 7:6 of `phase_o` are 00 or 11, which is the XNOR of those two bits.
- R8: `msin_o` and `mcos_o` follow the rules of R6 and R7 applied to `mod_phase_o`. When `pw_i` was 64 (a quarter turn), `msin_o` equals the previous cycle's `cos_o`.
- R9: An offset sum above 255 wraps. For example, a phase of 0xC0 plus an offset of 0x80 gives 0x40.
- R10: Whenever a section's carry register is 1, that section's new sum is no greater than its previous sum. Whenever the carry register is 0, the new sum is no smaller than the previous sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_i | input | 32 | Skewed frequency word: byte k lags byte 0 by k clocks |
| pw_i | input | 8 | Phase offset word, in 1/256ths of a turn |
| phase_o | output | 8 | Top byte of the accumulator |
| mod_phase_o | output | 8 | Registered sum of phase and offset, modulo 256 |
| sin_o | output | 1 | Square sine decoded from `phase_o` |
| cos_o | output | 1 | Square cosine decoded from `phase_o` |
| msin_o | output | 1 | Square sine decoded from `mod_phase_o` |
| mcos_o | output | 1 | Square cosine decoded from `mod_phase_o` |

## Verification
A word whose byte 0 is presented at edge e reaches `phase_o` through the top byte of the reference sum three edges later. `mod_phase_o` adds one further edge, and the offset word is consumed at the edge where it is presented. The square outputs change in the same cycle as the phase they decode. The bench's driver skews every word itself and advances a plain 32-bit accumulator. At each falling edge it queues the values due just after the next rising edge: the top byte from three edges back, and the top byte from four edges back plus the offset. The monitor pops one item two nanoseconds after each rising edge, so every comparison lands exactly in the cycle where the requirement places the result.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int unsigned NCO_SLICE_W = 8;
    localparam int unsigned NCO_SLICES  = 4;

    // First half of a turn: top bit clear.
    function automatic logic sq_sine(input logic top_bit);
        return ~top_bit;
    endfunction

    // First and last quarter: top two bits equal.
    function automatic logic sq_cosine(input logic top_bit, input logic next_bit);
        return ~(top_bit ^ next_bit);
    endfunction

endpackage

// File: rtl/nco_acc_slice.sv
module nco_acc_slice #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fw_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] wide_add;

    always_comb begin
        wide_add = {1'b0, sum_o} + {1'b0, fw_i} + {{W{1'b0}}, cin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o  <= '0;
            cout_o <= 1'b0;
        end else begin
            sum_o  <= wide_add[W-1:0];
            cout_o <= wide_add[W];
        end
    end

    // R10
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cout_o |-> (sum_o <= $past(sum_o)));

    // R10
    no_carry_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cout_o |-> (sum_o >= $past(sum_o)));

endmodule

// File: rtl/nco_phase_mod.sv
module nco_phase_mod #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] phase_i,
    input  logic [W-1:0] pw_i,
    output logic [W-1:0] mod_o
);
    logic [W-1:0] offset_sum;

    always_comb begin
        offset_sum = phase_i + pw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_o <= '0;
        end else begin
            mod_o <= offset_sum;
        end
    end

endmodule

// File: rtl/nco_square_out.sv
module nco_square_out #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] phase_i,
    output logic         sin_o,
    output logic         cos_o
);
    import nco_pkg::*;

    always_comb begin
        sin_o = sq_sine(phase_i[W-1]);
        cos_o = sq_cosine(phase_i[W-1], phase_i[W-2]);
    end

endmodule

// File: rtl/nco_pipe_core.sv
module nco_pipe_core #(
    parameter int unsigned SLICE_W    = nco_pkg::NCO_SLICE_W,
    parameter int unsigned NUM_SLICES = nco_pkg::NCO_SLICES,
    localparam int unsigned ACC_W     = SLICE_W * NUM_SLICES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   freq_i,
    input  logic [SLICE_W-1:0] pw_i,
    output logic [SLICE_W-1:0] phase_o,
    output logic [SLICE_W-1:0] mod_phase_o,
    output logic               sin_o,
    output logic               cos_o,
    output logic               msin_o,
    output logic               mcos_o
);
    localparam logic [SLICE_W-1:0] QUARTER_TURN = SLICE_W'(1) << (SLICE_W - 2);

    logic [NUM_SLICES:0] carry_chain;
    logic [SLICE_W-1:0]  section_sum [NUM_SLICES];

    assign carry_chain[0] = 1'b0;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_section
        nco_acc_slice #(.W(SLICE_W)) slice_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .fw_i   (freq_i[s*SLICE_W +: SLICE_W]),
            .cin_i  (carry_chain[s]),
            .sum_o  (section_sum[s]),
            .cout_o (carry_chain[s+1])
        );
    end

    assign phase_o = section_sum[NUM_SLICES-1];

    nco_phase_mod #(.W(SLICE_W)) offset_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_o),
        .pw_i    (pw_i),
        .mod_o   (mod_phase_o)
    );

    nco_square_out #(.W(SLICE_W)) plain_sq_i (
        .phase_i (phase_o),
        .sin_o   (sin_o),
        .cos_o   (cos_o)
    );

    nco_square_out #(.W(SLICE_W)) offset_sq_i (
        .phase_i (mod_phase_o),
        .sin_o   (msin_o),
        .cos_o   (mcos_o)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase_o == '0 && mod_phase_o == '0));

    // R5
    zero_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pw_i) == '0) |-> (mod_phase_o == $past(phase_o)));

    // R8
    quarter_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pw_i) == QUARTER_TURN) |-> (msin_o == $past(cos_o)));

endmodule

// File: tb/nco_pipe_core_tb_top.sv
`timescale 1ns/1ps
module nco_pipe_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] freq_i;
    logic [7:0]  pw_i;
    logic [7:0]  phase_o, mod_phase_o;
    logic        sin_o, cos_o, msin_o, mcos_o;

    always #4 clk = ~clk;

    nco_pipe_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .freq_i      (freq_i),
        .pw_i        (pw_i),
        .phase_o     (phase_o),
        .mod_phase_o (mod_phase_o),
        .sin_o       (sin_o),
        .cos_o       (cos_o),
        .msin_o      (msin_o),
        .mcos_o      (mcos_o)
    );

    typedef struct {
        logic [7:0] ph;
        logic [7:0] md;
        string      tag;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] word_hist [4];
    logic [31:0] acc_hist  [5];
    int          checks = 0;
    int          errors = 0;
    logic        done   = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: skew the word, advance the reference sum, queue expectations.
    task automatic drive(input logic [31:0] w, input logic [7:0] pw, input string tag);
        exp_t it;
        @(negedge clk);
        for (int k = 3; k > 0; k--) word_hist[k] = word_hist[k-1];
        word_hist[0] = w;
        for (int k = 0; k < 4; k++) freq_i[8*k +: 8] = word_hist[k][8*k +: 8];
        pw_i = pw;
        for (int i = 4; i > 0; i--) acc_hist[i] = acc_hist[i-1];
        acc_hist[0] = acc_hist[1] + w;
        it.ph  = acc_hist[3][31:24];
        it.md  = acc_hist[4][31:24] + pw;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare two nanoseconds after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            exp_t it;
            it = sbq.pop_front();
            chk($sformatf("R2 %s phase", it.tag), phase_o, it.ph);
            chk($sformatf("R5 %s offset phase", it.tag), mod_phase_o, it.md);
            chk("R6 sine", {7'd0, sin_o}, {7'd0, ~it.ph[7]});
            chk("R7 cosine", {7'd0, cos_o}, {7'd0, it.ph[7] ~^ it.ph[6]});
            chk("R8 offset sine", {7'd0, msin_o}, {7'd0, ~it.md[7]});
            chk("R8 offset cosine", {7'd0, mcos_o}, {7'd0, it.md[7] ~^ it.md[6]});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        freq_i = '0;
        pw_i   = '0;
        for (int k = 0; k < 4; k++) word_hist[k] = '0;
        for (int i = 0; i < 5; i++) acc_hist[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk("R1 phase", phase_o, 8'h00);
        chk("R1 offset phase", mod_phase_o, 8'h00);
        chk("R1 sine", {7'd0, sin_o}, 8'h01);
        chk("R1 cosine", {7'd0, cos_o}, 8'h01);
        chk("R1 offset sine", {7'd0, msin_o}, 8'h01);
        chk("R1 offset cosine", {7'd0, mcos_o}, 8'h01);
        rst_n = 1'b1;

        for (int i = 0; i < 40; i++) drive(32'h0123_4567, 8'h00, "R2");
        for (int i = 0; i < 30; i++) drive(32'hFFFF_FFFF, 8'h00, "R3");
        for (int i = 0; i < 20; i++) drive(32'h00FF_FFFF, 8'h00, "R3");
        for (int i = 0; i < 30; i++) drive(32'h9E37_79B9 * (i + 1), 8'h00, "R4");
        for (int i = 0; i < 64; i++) drive(32'h0400_0000, 8'((i * 37) & 8'hFF), "R5");
        for (int i = 0; i < 20; i++) drive(32'h0C00_0000, (i % 2 == 0) ? 8'hFF : 8'h80, "R9");
        for (int i = 0; i < 80; i++) drive(32'h0200_0000, 8'd64, "R8");
        for (int i = 0; i < 3; i++) drive(32'h0000_0000, 8'h00, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule